// File: doc/BRIEF.md
# Hardware Breakpoint Debug Engine

This block sits beside a CPU core and watches each access the core presents: instruction fetches, data reads, data writes and register writes. Each access is compared against a small bank of breakpoint slots programmed from a host command port. When an enabled slot matches, the engine drops a halt request onto the core in the same cycle. It records which slot fired in a sticky status field and moves into its debug mode.

The engine has three modes. After reset it is off, and breakpoints are inert. An arm command moves it to background mode. There breakpoints are live and the host can reprogram them while the core keeps running. Debug mode can only be reached from background mode, either by a breakpoint firing or by an explicit halt command. While in debug mode the core stays stopped and breakpoints are masked. The host can reach the core's registers and memory through a forwarded access bus. It can also single-step one instruction, or resume, which drops the engine back to background mode.

The host port takes one command per cycle, in the manner of a scan data register updating a shift chain. Read results appear on the host read bus one cycle after the command.

Top module: `dbg_bkpt_engine`

## Requirements
- R1: After reset the mode is off (code 0), `cpu_halt` is low, every sticky status bit is zero and every breakpoint slot reads back as zero.
- R2: Op 5 (arm) moves the engine from off to background (code 1). Op 6 (disarm) moves it from background to off. In off mode no access ever raises `cpu_halt`.
- R3: Op 1 writes slot `host_addr[1:0]` with address in `host_wdata[15:0]`, kind in `[17:16]` and enable in `[18]`. Op 2 reads the slot back in the same layout. Both work in any mode and never stop the core.
- R4: In background mode, an access matches a slot when the slot is enabled, the kind is equal and the address is equal. Kind codes are 0 fetch, 1 data read, 2 data write and 3 register write. On a match, `cpu_halt` is high in the same cycle as the access and the mode becomes debug (code 2) on the next cycle.
- R5: Status (op 3) bits [3:0] hold one sticky bit per slot, set when that slot fires. Only op 4 clears them.
- R6: Op 7 (halt) enters debug mode only from background. In off mode it has no effect.
- R7: In debug mode `cpu_halt` stays high and no slot fires or sets a status bit.
- R8: Op 8 (resume) leaves debug mode for background, not off. Status bits [9:8] report the mode.
- R9: After a resume, the slots that caused the halt are ignored until the second fetch after the resume. Other slots fire normally in that window.
- R10: Op 9 (step) in debug mode lowers `cpu_halt` for exactly one fetch. It raises `cpu_halt` again in the same cycle as the next fetch. The mode stays debug throughout, and status bit [10] is high while a step runs.
- R11: Ops 10 (target read) and 11 (target write) drive the target bus with `host_addr` and `host_wdata` only in debug mode. The read data reaches `host_rdata` one cycle later. In other modes no target request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_valid | input | 1 | Host command strobe |
| host_op | input | 4 | Host command code |
| host_addr | input | 16 | Slot index or target address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read result, valid one cycle after the command |
| cpu_valid | input | 1 | Core presents an access this cycle |
| cpu_kind | input | 2 | Access kind |
| cpu_addr | input | 16 | Access address |
| cpu_halt | output | 1 | Halt request; the access is not taken while high |
| tgt_req | output | 1 | Forwarded register/memory access request |
| tgt_we | output | 1 | Forwarded access is a write |
| tgt_addr | output | 16 | Forwarded access address |
| tgt_wdata | output | 32 | Forwarded write data |
| tgt_rdata | input | 32 | Forwarded read data, same cycle |

## Verification
The comparators are tried with access streams that differ from a match in only one way: a wrong kind at the right address, a right kind at the wrong address, and a disabled slot. These show that the kind and the enable are both part of the match. Resume sequences present the halting access again, then another slot's access, then a second fetch, which shows when the resume mask ends. A random stream over eight addresses and all four kinds is checked against a bench model of the resume mask. Reprogramming in the middle of the stream shows that slot writes leave the core running.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
    localparam int DBG_AW  = 16;
    localparam int DBG_DW  = 32;
    localparam int DBG_NBP = 4;
    localparam int STAT_MODE_LSB = 8;
    localparam int STAT_STEP_BIT = 10;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_DRD   = 2'd1,
        ACC_DWR   = 2'd2,
        ACC_REGWR = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        MODE_OFF = 2'd0,
        MODE_BG  = 2'd1,
        MODE_DBG = 2'd2
    } dbg_mode_e;

    typedef enum logic [3:0] {
        OP_NOP      = 4'd0,
        OP_WR_BP    = 4'd1,
        OP_RD_BP    = 4'd2,
        OP_RD_STAT  = 4'd3,
        OP_CLR_STAT = 4'd4,
        OP_ARM      = 4'd5,
        OP_DISARM   = 4'd6,
        OP_HALT     = 4'd7,
        OP_RESUME   = 4'd8,
        OP_STEP     = 4'd9,
        OP_MEM_RD   = 4'd10,
        OP_MEM_WR   = 4'd11
    } host_op_e;

    typedef struct packed {
        logic                en;
        acc_kind_e           kind;
        logic [DBG_AW-1:0]   addr;
    } bp_cfg_t;

    localparam int BP_W = $bits(bp_cfg_t);

    function automatic bp_cfg_t word_to_bp(input logic [DBG_DW-1:0] w);
        return bp_cfg_t'(w[BP_W-1:0]);
    endfunction

    function automatic logic [DBG_DW-1:0] bp_to_word(input bp_cfg_t c);
        return {{(DBG_DW-BP_W){1'b0}}, c};
    endfunction
endpackage

// File: rtl/dbg_bp_slot.sv
module dbg_bp_slot
    import dbg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  bp_cfg_t           wr_cfg,
    input  logic              acc_valid,
    input  acc_kind_e         acc_kind,
    input  logic [DBG_AW-1:0] acc_addr,
    output bp_cfg_t           cfg,
    output logic              hit
);
    always_ff @(posedge clk) begin
        if (rst)        cfg <= '0;
        else if (wr_en) cfg <= wr_cfg;
    end

    assign hit = cfg.en && acc_valid && (acc_kind == cfg.kind) && (acc_addr == cfg.addr);

    // R3: slot contents change only on a host write
    p_cfg_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(cfg));
endmodule

// File: rtl/dbg_mode_ctrl.sv
module dbg_mode_ctrl
    import dbg_pkg::*;
#(
    parameter int NBP = DBG_NBP
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cmd_arm,
    input  logic           cmd_disarm,
    input  logic           cmd_halt,
    input  logic           cmd_resume,
    input  logic           cmd_step,
    input  logic           acc_valid,
    input  acc_kind_e      acc_kind,
    input  logic [NBP-1:0] hit_vec,
    output dbg_mode_e      mode,
    output logic           halt,
    output logic           step_active,
    output logic [NBP-1:0] fire_vec
);
    dbg_mode_e      mode_q;
    logic [NBP-1:0] last_vec_q, skip_vec_q, eff_hits;
    logic           skip_q, skip_seen_q, step_q, step_seen_q;
    logic           is_fetch, skip_live, step_stop;

    assign is_fetch  = acc_valid && (acc_kind == ACC_FETCH);
    // the mask ends on the second fetch after resume, which is then compared normally
    assign skip_live = skip_q && !(skip_seen_q && is_fetch);
    assign eff_hits  = hit_vec & ~(skip_live ? skip_vec_q : '0);
    assign fire_vec  = (mode_q == MODE_BG) ? eff_hits : '0;
    assign step_stop = step_q && step_seen_q && is_fetch;
    assign halt      = ((mode_q == MODE_DBG) && (!step_q || step_stop)) || (|fire_vec);
    assign mode        = mode_q;
    assign step_active = step_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q      <= MODE_OFF;
            last_vec_q  <= '0;
            skip_vec_q  <= '0;
            skip_q      <= 1'b0;
            skip_seen_q <= 1'b0;
            step_q      <= 1'b0;
            step_seen_q <= 1'b0;
        end else begin
            unique case (mode_q)
                MODE_OFF: begin
                    if (cmd_arm) mode_q <= MODE_BG;
                end
                MODE_BG: begin
                    if (|fire_vec) begin
                        mode_q     <= MODE_DBG;
                        last_vec_q <= fire_vec;
                        skip_q     <= 1'b0;
                    end else if (cmd_halt) begin
                        mode_q     <= MODE_DBG;
                        last_vec_q <= '0;
                        skip_q     <= 1'b0;
                    end else if (cmd_disarm) begin
                        mode_q <= MODE_OFF;
                        skip_q <= 1'b0;
                    end else if (skip_q && is_fetch) begin
                        if (skip_seen_q) skip_q      <= 1'b0;
                        else             skip_seen_q <= 1'b1;
                    end
                end
                MODE_DBG: begin
                    if (cmd_resume) begin
                        mode_q      <= MODE_BG;
                        skip_q      <= |last_vec_q;
                        skip_vec_q  <= last_vec_q;
                        skip_seen_q <= 1'b0;
                        step_q      <= 1'b0;
                    end else if (cmd_step && !step_q) begin
                        step_q      <= 1'b1;
                        step_seen_q <= 1'b0;
                        last_vec_q  <= '0;
                    end else if (step_q && is_fetch) begin
                        if (step_seen_q) step_q      <= 1'b0;
                        else             step_seen_q <= 1'b1;
                    end
                end
                default: mode_q <= MODE_OFF;
            endcase
        end
    end

    // R4: a fired slot puts the engine in debug mode on the next cycle
    p_fire_enters_dbg_r4: assert property (@(posedge clk) disable iff (rst)
        (|fire_vec) |=> (mode_q == MODE_DBG));
    // R6: debug mode is only reached from background mode
    p_dbg_from_bg_r6: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_DBG && $past(mode_q) != MODE_DBG) |-> ($past(mode_q) == MODE_BG));
    // R8: resume lands in background mode
    p_resume_to_bg_r8: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_DBG && cmd_resume) |=> (mode_q == MODE_BG));
    // R2: off mode never halts
    p_off_no_halt_r2: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_OFF) |-> (!halt && fire_vec == '0));
    // R10: a step never leaves debug mode
    p_step_in_dbg_r10: assert property (@(posedge clk) disable iff (rst)
        step_q |-> (mode_q == MODE_DBG));
endmodule

// File: rtl/dbg_bkpt_engine.sv
module dbg_bkpt_engine
    import dbg_pkg::*;
#(
    parameter int NBP = DBG_NBP
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_valid,
    input  logic [3:0]        host_op,
    input  logic [DBG_AW-1:0] host_addr,
    input  logic [DBG_DW-1:0] host_wdata,
    output logic [DBG_DW-1:0] host_rdata,
    input  logic              cpu_valid,
    input  logic [1:0]        cpu_kind,
    input  logic [DBG_AW-1:0] cpu_addr,
    output logic              cpu_halt,
    output logic              tgt_req,
    output logic              tgt_we,
    output logic [DBG_AW-1:0] tgt_addr,
    output logic [DBG_DW-1:0] tgt_wdata,
    input  logic [DBG_DW-1:0] tgt_rdata
);
    localparam int IW = (NBP > 1) ? $clog2(NBP) : 1;

    host_op_e       op;
    acc_kind_e      kind;
    dbg_mode_e      mode;
    bp_cfg_t        cfg_arr [NBP];
    logic [NBP-1:0] hit_vec, fire_vec, sticky_q;
    logic           step_active, clr_stat;
    logic [IW-1:0]  slot_idx;
    logic [DBG_DW-1:0] stat_word;

    assign op       = host_op_e'(host_op);
    assign kind     = acc_kind_e'(cpu_kind);
    assign slot_idx = host_addr[IW-1:0];
    assign clr_stat = host_valid && (op == OP_CLR_STAT);

    for (genvar g = 0; g < NBP; g++) begin : g_slot
        dbg_bp_slot u_slot (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (host_valid && (op == OP_WR_BP) && (slot_idx == IW'(g))),
            .wr_cfg   (word_to_bp(host_wdata)),
            .acc_valid(cpu_valid),
            .acc_kind (kind),
            .acc_addr (cpu_addr),
            .cfg      (cfg_arr[g]),
            .hit      (hit_vec[g])
        );
    end

    dbg_mode_ctrl #(.NBP(NBP)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .cmd_arm    (host_valid && (op == OP_ARM)),
        .cmd_disarm (host_valid && (op == OP_DISARM)),
        .cmd_halt   (host_valid && (op == OP_HALT)),
        .cmd_resume (host_valid && (op == OP_RESUME)),
        .cmd_step   (host_valid && (op == OP_STEP)),
        .acc_valid  (cpu_valid),
        .acc_kind   (kind),
        .hit_vec    (hit_vec),
        .mode       (mode),
        .halt       (cpu_halt),
        .step_active(step_active),
        .fire_vec   (fire_vec)
    );

    assign tgt_req   = host_valid && (mode == MODE_DBG) && (op == OP_MEM_RD || op == OP_MEM_WR);
    assign tgt_we    = tgt_req && (op == OP_MEM_WR);
    assign tgt_addr  = host_addr;
    assign tgt_wdata = host_wdata;

    always_ff @(posedge clk) begin
        if (rst)           sticky_q <= '0;
        else if (clr_stat) sticky_q <= fire_vec;
        else               sticky_q <= sticky_q | fire_vec;
    end

    always_comb begin
        stat_word = '0;
        stat_word[NBP-1:0] = sticky_q;
        stat_word[STAT_MODE_LSB +: 2] = mode;
        stat_word[STAT_STEP_BIT] = step_active;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            host_rdata <= '0;
        end else if (host_valid) begin
            case (op)
                OP_RD_BP:   host_rdata <= bp_to_word(cfg_arr[slot_idx]);
                OP_RD_STAT: host_rdata <= stat_word;
                OP_MEM_RD:  if (mode == MODE_DBG) host_rdata <= tgt_rdata;
                default:    ;
            endcase
        end
    end

    // R5: status bits are lost only through the clear command
    p_sticky_keep_r5: assert property (@(posedge clk) disable iff (rst)
        !clr_stat |=> ((sticky_q & $past(sticky_q)) == $past(sticky_q)));
    // R11: no forwarded access outside debug mode
    p_tgt_only_dbg_r11: assert property (@(posedge clk) disable iff (rst)
        (mode != MODE_DBG) |-> !tgt_req);
endmodule

// File: tb/dbg_bkpt_engine_test.sv
module dbg_bkpt_engine_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_valid = 1'b0;
    logic [3:0]  host_op = 4'd0;
    logic [15:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        cpu_valid = 1'b0;
    logic [1:0]  cpu_kind = 2'd0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_halt, tgt_req, tgt_we;
    logic [15:0] tgt_addr;
    logic [31:0] tgt_wdata;
    logic [31:0] tgt_rdata = 32'h1234_ABCD;

    int checks = 0;
    int fails  = 0;
    logic        s_req, s_we;
    logic [15:0] s_addr;
    logic [31:0] s_wdata;

    logic [15:0] m_addr [4];
    logic [1:0]  m_kind [4];
    logic        m_en   [4];

    dbg_bkpt_engine uut (.*);

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host(input logic [3:0] op, input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        cpu_valid = 1'b0; host_valid = 1'b1; host_op = op; host_addr = a; host_wdata = d;
        #8;
        s_req = tgt_req; s_we = tgt_we; s_addr = tgt_addr; s_wdata = tgt_wdata;
    endtask

    task automatic host_rd(input logic [3:0] op, input logic [15:0] a, output logic [31:0] r);
        host(op, a, 32'd0);
        @(negedge clk);
        host_valid = 1'b0;
        #1 r = host_rdata;
    endtask

    task automatic cpu(input logic [1:0] k, input logic [15:0] a, output logic h);
        @(negedge clk);
        host_valid = 1'b0; cpu_valid = 1'b1; cpu_kind = k; cpu_addr = a;
        #8 h = cpu_halt;
    endtask

    task automatic set_bp(input int i, input logic en, input logic [1:0] k, input logic [15:0] a);
        m_en[i] = en; m_kind[i] = k; m_addr[i] = a;
        host(4'd1, 16'(i), {13'd0, en, k, a});
    endtask

    function automatic logic [3:0] model_hits(input logic [1:0] k, input logic [15:0] a);
        logic [3:0] v = '0;
        for (int i = 0; i < 4; i++) v[i] = m_en[i] && m_kind[i] == k && m_addr[i] == a;
        return v;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic h;
        int nf;
        logic [1:0]  rk;
        logic [15:0] ra;
        logic have;
        logic [3:0] exp_fire, sk_vec;
        logic sk, sk_seen, sk_live;
        int unsigned seed_v;

        for (int i = 0; i < 4; i++) begin m_en[i] = 0; m_kind[i] = 0; m_addr[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #8 chk(cpu_halt == 1'b0, "R1 halt low", 32'(cpu_halt), 0);
        host_rd(4'd3, 0, r); chk(r == 0, "R1 status", r, 0);
        host_rd(4'd2, 0, r); chk(r == 0, "R1 slot", r, 0);

        set_bp(0, 1, 2'd0, 16'h0040);
        set_bp(1, 1, 2'd2, 16'h0080);
        set_bp(2, 1, 2'd0, 16'h0044);
        host_rd(4'd2, 0, r); chk(r == 32'h0004_0040, "R3 readback", r, 32'h0004_0040);
        host_rd(4'd2, 1, r); chk(r == 32'h0006_0080, "R3 readback", r, 32'h0006_0080);

        // off mode
        cpu(2'd0, 16'h0040, h); chk(h == 0, "R2 off no halt", 32'(h), 0);
        host(4'd7, 0, 0);
        host_rd(4'd3, 0, r); chk(r == 0, "R6 halt ignored in off", r, 0);
        host(4'd10, 16'h0010, 0); chk(s_req == 0, "R11 no req in off", 32'(s_req), 0);

        host(4'd5, 0, 0);
        host_rd(4'd3, 0, r); chk(r == 32'h100, "R2 armed", r, 32'h100);

        cpu(2'd1, 16'h0080, h); chk(h == 0, "R4 kind mismatch", 32'(h), 0);
        cpu(2'd0, 16'h0010, h); chk(h == 0, "R4 addr mismatch", 32'(h), 0);
        cpu(2'd0, 16'h0040, h); chk(h == 1, "R4 same-cycle halt", 32'(h), 1);
        host_rd(4'd3, 0, r); chk(r == 32'h201, "R5 R8 status after hit", r, 32'h201);

        cpu(2'd0, 16'h0044, h); chk(h == 1, "R7 held in debug", 32'(h), 1);
        host_rd(4'd3, 0, r); chk(r == 32'h201, "R7 masked", r, 32'h201);

        host(4'd11, 16'h0123, 32'hCAFE_0001);
        chk(s_req && s_we && s_addr == 16'h0123 && s_wdata == 32'hCAFE_0001, "R11 write fwd",
            {s_req, s_we, 14'd0, s_addr}, 32'hC000_0123);
        host_rd(4'd10, 16'h0020, r); chk(r == 32'h1234_ABCD, "R11 read data", r, 32'h1234_ABCD);

        // single step
        host(4'd9, 0, 0);
        nf = 0;
        cpu(2'd0, 16'h0040, h); chk(h == 0, "R10 step fetch runs", 32'(h), 0); if (!h) nf++;
        cpu(2'd2, 16'h0080, h); chk(h == 0, "R10 data in step", 32'(h), 0);
        cpu(2'd0, 16'h0044, h); chk(h == 1, "R10 halt on next fetch", 32'(h), 1); if (!h) nf++;
        chk(nf == 1, "R10 step count", 32'(nf), 1);
        host_rd(4'd3, 0, r); chk(r == 32'h201, "R10 still debug", r, 32'h201);

        host(4'd4, 0, 0);
        host_rd(4'd3, 0, r); chk(r == 32'h200, "R5 cleared", r, 32'h200);

        // resume mask
        host(4'd8, 0, 0);
        cpu(2'd0, 16'h0044, h); chk(h == 1, "R9 step left no mask", 32'(h), 1);
        host_rd(4'd3, 0, r); chk(r == 32'h204, "R5 slot2 sticky", r, 32'h204);
        host(4'd8, 0, 0);
        host_rd(4'd3, 0, r); chk(r == 32'h104, "R8 resume to background", r, 32'h104);
        cpu(2'd0, 16'h0044, h); chk(h == 0, "R9 first fetch masked", 32'(h), 0);
        cpu(2'd2, 16'h0080, h); chk(h == 1, "R9 other slot fires", 32'(h), 1);
        host(4'd8, 0, 0);
        cpu(2'd2, 16'h0080, h); chk(h == 0, "R9 data masked", 32'(h), 0);
        cpu(2'd0, 16'h0048, h); chk(h == 0, "R9 no match", 32'(h), 0);
        cpu(2'd0, 16'h0044, h); chk(h == 1, "R9 second fetch", 32'(h), 1);
        host(4'd8, 0, 0);
        cpu(2'd0, 16'h0044, h); chk(h == 0, "R9 refetch masked", 32'(h), 0);
        cpu(2'd0, 16'h0044, h); chk(h == 1, "R9 mask over", 32'(h), 1);
        host(4'd8, 0, 0);

        host(4'd6, 0, 0);
        host_rd(4'd3, 0, r); chk(r[9:8] == 2'd0, "R2 disarm", 32'(r[9:8]), 0);
        cpu(2'd0, 16'h0040, h); chk(h == 0, "R2 off no halt", 32'(h), 0);
        host(4'd7, 0, 0);
        host_rd(4'd3, 0, r); chk(r[9:8] == 2'd0, "R6 off halt ignored", 32'(r[9:8]), 0);
        host(4'd5, 0, 0);
        host(4'd7, 0, 0);
        host_rd(4'd3, 0, r); chk(r[9:8] == 2'd2, "R6 halt from background", 32'(r[9:8]), 2);
        host(4'd8, 0, 0);
        host(4'd4, 0, 0);
        host(4'd10, 16'h0010, 0); chk(s_req == 0, "R11 no req in background", 32'(s_req), 0);

        // random stream
        seed_v = $urandom(32'd4242);
        for (int i = 0; i < 4; i++)
            set_bp(i, 1'($urandom % 4 != 0), 2'($urandom), 16'(($urandom % 8) * 4));
        sk = 0; sk_seen = 0; sk_vec = '0; have = 0; rk = 0; ra = 0;
        for (int it = 0; it < 1500; it++) begin
            if (it == 700) begin
                for (int i = 0; i < 4; i++)
                    set_bp(i, 1'($urandom % 4 != 0), 2'($urandom), 16'(($urandom % 8) * 4));
                host_rd(4'd3, 0, r); chk(r[9:8] == 2'd1, "R3 write while running", 32'(r[9:8]), 1);
            end
            if (!have) begin
                rk = 2'($urandom); ra = 16'(($urandom % 8) * 4); have = 1;
            end
            sk_live = sk && !(sk_seen && rk == 2'd0);
            exp_fire = model_hits(rk, ra) & ~(sk_live ? sk_vec : 4'd0);
            cpu(rk, ra, h);
            chk(h == (|exp_fire), "R4 R9 random halt", 32'(h), 32'(|exp_fire));
            if (h) begin
                host_rd(4'd3, 0, r);
                chk(r[3:0] == exp_fire && r[9:8] == 2'd2, "R5 random status", r, {22'd0, 2'd2, 4'd0, exp_fire});
                host(4'd4, 0, 0);
                host(4'd8, 0, 0);
                sk = |exp_fire; sk_vec = exp_fire; sk_seen = 0;
            end else begin
                have = 0;
                if (sk && rk == 2'd0) begin
                    if (sk_seen) sk = 0; else sk_seen = 1;
                end
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule